// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

The block holds two 8-bit up-counters that share one clock and one prescaler. Each channel picks its count source in its own control register. It can take a prescaled tick of the system clock, with a divide ratio of 1, 8, 32 or 64. Channel 0 has one more option: it can count each overflow of channel 1. In that mode the pair acts as a single 16-bit counter, with channel 0 as the high byte. Each channel also has two compare registers. A match on either one sets a status flag, and a compare-A match can clear the count.

Software reaches the timer over a simple synchronous bus. A byte access goes to one register of one channel. A word access goes to the same register in both channels at once, with channel 0 in the upper byte. Read data depends only on the address and the stored state, so a read never yields an undefined value. Every count enable is a one-cycle pulse in the same clock domain, and no clock is ever gated.

Top module: `dtmr_top`

## Requirements
- R1: On a count event a channel's count goes from 0xFF to 0x00 and sets that channel's overflow flag, which is status bit 2.
- R2: Control bits 2:1 set the internal divide ratio: 0 gives every cycle, 1 gives 1/8, 2 gives 1/32 and 3 gives 1/64. Take the rising edges after reset release, numbered k = 0, 1, 2 and so on. A divide-by-N tick falls on each edge where k mod N equals N-1.
- R3: When control bit 0 of channel 0 is set, channel 0 counts once per channel 1 overflow and ignores its internal tick. Control bit 0 of channel 1 is stored but has no effect on counting.
- R4: Register 0 holds the count. A word read returns channel 0 in bits 15:8 and channel 1 in bits 7:0. A byte read returns the channel chosen by bus_ch (0 or 1) in bits 7:0, with zeros above.
- R5: Registers 1 and 2 hold compare A and compare B. They use the same byte and word layout as the count, for both reads and writes.
- R6: If a channel has no count event and no write, its count and flags stay as they are. Repeated reads return the same stored value.
- R7: On a count event, status bit 0 is set when the count before the event equals compare A. Status bit 1 is set in the same way for compare B.
- R8: Register 4 is the status. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. A flag that is set by an event in the same cycle stays set.
- R9: When control bit 3 is set, a compare-A match on a count event loads 0 into the count instead of incrementing it, and no overflow is raised.
- R10: A word write to any register updates both channels on the same clock edge.
- R11: A write to a channel's count takes priority over a count event in the same cycle. This includes a cascade overflow arriving at channel 0, and that overflow is then lost.
- R12: Register 3 is the control register and reads back bits 3:0. Read data is zero whenever bus_en is low, bus_wr is high, or the address is 5 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = word access to both channels |
| bus_ch | input | 1 | Channel for a byte access |
| bus_addr | input | 3 | Register select (0 count, 1 compare A, 2 compare B, 3 control, 4 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address and the stored state |

## Verification
A read is due within the same cycle that drives it, so the bench samples read data one time unit after it drives the bus on the falling edge. Writes, count events, flag updates and compare clears all take effect on the next rising edge. A register read in the following cycle therefore shows them. The bench model advances exactly once per rising edge, using the inputs that were held across that edge, and it derives the prescaler phase from the edge count k. Every comparison therefore lines up with the cycle in which the design's registers change.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int CW   = 8;
    localparam int NDIV = 4;

    localparam logic [2:0] RG_COUNT = 3'd0;
    localparam logic [2:0] RG_CMPA  = 3'd1;
    localparam logic [2:0] RG_CMPB  = 3'd2;
    localparam logic [2:0] RG_CTRL  = 3'd3;
    localparam logic [2:0] RG_STAT  = 3'd4;

    localparam int CB_CASC   = 0;
    localparam int CB_DIV_LO = 1;
    localparam int CB_CLR    = 3;

    localparam int ST_MA  = 0;
    localparam int ST_MB  = 1;
    localparam int ST_OVF = 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmpa;
        logic [CW-1:0] cmpb;
        logic [3:0]    ctl;
        logic [2:0]    st;
    } chan_state_t;

    function automatic int div_log(int i);
        case (i)
            0:       return 0;
            1:       return 3;
            2:       return 5;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/dtmr_presc.sv
module dtmr_presc
    import dtmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [NDIV-1:0] tick_vec
);
    localparam int PW = div_log(NDIV-1);

    logic [PW-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q + {{(PW-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_tap
        localparam int L = div_log(g);
        if (L == 0) begin : g_full
            assign tick_vec[g] = 1'b1;
        end else begin : g_div
            assign tick_vec[g] = &pc_q[L-1:0];
        end
    end

    // R2: a slower tap only fires on cycles where every faster tap fires
    a_r2_nested_taps: assert property (@(posedge clk) disable iff (!rst_n)
        tick_vec[3] |-> (tick_vec[2] && tick_vec[1] && tick_vec[0]));
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter bit CASC_EN = 1'b1
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDIV-1:0] tick_vec,
    input  logic            casc_evt,
    input  logic            wr_cnt,
    input  logic            wr_cmpa,
    input  logic            wr_cmpb,
    input  logic            wr_ctl,
    input  logic            wr_st,
    input  logic [CW-1:0]   wbyte,
    output chan_state_t     state,
    output logic            ovf_evt
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] ONE     = {{(CW-1){1'b0}}, 1'b1};

    chan_state_t s_d, s_q;
    logic tick_sel, evt, hit_a, hit_b, do_clr;

    always_comb begin
        tick_sel = tick_vec[s_q.ctl[CB_DIV_LO +: 2]];
        if (CASC_EN && s_q.ctl[CB_CASC]) evt = casc_evt & ~wr_cnt;
        else                             evt = tick_sel & ~wr_cnt;
        hit_a   = evt && (s_q.cnt == s_q.cmpa);
        hit_b   = evt && (s_q.cnt == s_q.cmpb);
        do_clr  = hit_a && s_q.ctl[CB_CLR];
        ovf_evt = evt && !do_clr && (s_q.cnt == CNT_MAX);

        s_d = s_q;
        if (wr_cnt)      s_d.cnt = wbyte;
        else if (do_clr) s_d.cnt = '0;
        else if (evt)    s_d.cnt = s_q.cnt + ONE;
        if (wr_cmpa) s_d.cmpa = wbyte;
        if (wr_cmpb) s_d.cmpb = wbyte;
        if (wr_ctl)  s_d.ctl  = wbyte[3:0];
        if (wr_st)   s_d.st   = s_q.st & wbyte[2:0];
        s_d.st[ST_MA]  = s_d.st[ST_MA]  | hit_a;
        s_d.st[ST_MB]  = s_d.st[ST_MB]  | hit_b;
        s_d.st[ST_OVF] = s_d.st[ST_OVF] | ovf_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign state = s_q;

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && s_q.cnt == CNT_MAX && !(s_q.ctl[CB_CLR] && s_q.cmpa == CNT_MAX))
        |=> (s_q.cnt == '0 && s_q.st[ST_OVF]));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !wr_cnt) |=> $stable(s_q.cnt));

    a_r7_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && s_q.cnt == s_q.cmpa) |=> s_q.st[ST_MA]);

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (s_q.cnt == $past(wbyte)));
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_wr,
    input  logic            bus_word,
    input  logic            bus_ch,
    input  logic [2:0]      bus_addr,
    input  logic [2*CW-1:0] bus_wdata,
    output logic [2*CW-1:0] bus_rdata
);
    logic [NDIV-1:0]       tick_vec;
    chan_state_t [1:0]     cs_v;
    logic [1:0]            ovf_v;
    logic [1:0]            wr_cnt_v;
    logic [1:0][CW-1:0]    rb;

    dtmr_presc u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_vec (tick_vec)
    );

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic          hit;
        logic [CW-1:0] wb;
        logic          casc;

        assign hit  = bus_en && bus_wr && (bus_word || (bus_ch == 1'(c)));
        assign wb   = (bus_word && c == 0) ? bus_wdata[2*CW-1:CW] : bus_wdata[CW-1:0];
        assign casc = (c == 0) ? ovf_v[1] : 1'b0;
        assign wr_cnt_v[c] = hit && (bus_addr == RG_COUNT);

        dtmr_chan #(.CASC_EN(c == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_vec (tick_vec),
            .casc_evt (casc),
            .wr_cnt   (wr_cnt_v[c]),
            .wr_cmpa  (hit && (bus_addr == RG_CMPA)),
            .wr_cmpb  (hit && (bus_addr == RG_CMPB)),
            .wr_ctl   (hit && (bus_addr == RG_CTRL)),
            .wr_st    (hit && (bus_addr == RG_STAT)),
            .wbyte    (wb),
            .state    (cs_v[c]),
            .ovf_evt  (ovf_v[c])
        );
    end

    always_comb begin
        for (int c = 0; c < 2; c++) begin
            case (bus_addr)
                RG_COUNT: rb[c] = cs_v[c].cnt;
                RG_CMPA:  rb[c] = cs_v[c].cmpa;
                RG_CMPB:  rb[c] = cs_v[c].cmpb;
                RG_CTRL:  rb[c] = {{(CW-4){1'b0}}, cs_v[c].ctl};
                RG_STAT:  rb[c] = {{(CW-3){1'b0}}, cs_v[c].st};
                default:  rb[c] = '0;
            endcase
        end
        if (!(bus_en && !bus_wr)) bus_rdata = '0;
        else if (bus_word)        bus_rdata = {rb[0], rb[1]};
        else                      bus_rdata = {{CW{1'b0}}, (bus_ch ? rb[1] : rb[0])};
    end

    // R3: in cascade the high channel moves only on a low-channel overflow or a write
    a_r3_cascade_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_v[0].ctl[CB_CASC] && !ovf_v[1] && !wr_cnt_v[0]) |=> $stable(cs_v[0].cnt));
endmodule

// File: tb/sim_dtmr_top.sv
module sim_dtmr_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_wr, bus_word, bus_ch;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    string cur = "R4";

    int m_cnt [2];
    int m_ca  [2];
    int m_cb  [2];
    int m_ctl [2];
    int m_st  [2];
    int k;

    always #(CLK_P/2) clk = ~clk;

    dtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_ch(bus_ch), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic int reg_of(int c, int a);
        case (a)
            0: return m_cnt[c];
            1: return m_ca[c];
            2: return m_cb[c];
            3: return m_ctl[c];
            4: return m_st[c];
            default: return 0;
        endcase
    endfunction

    function automatic int model_rd(bit en, bit wr, bit word, bit ch, int a);
        if (!(en && !wr)) return 0;
        if (word) return reg_of(0, a) * 256 + reg_of(1, a);
        return reg_of(ch ? 1 : 0, a);
    endfunction

    function automatic void model_step(bit en, bit wr, bit word, bit ch, int a, int wd);
        bit ovf1 = 0;
        for (int c = 1; c >= 0; c--) begin
            bit wrh, tick, src, e, ha, hb, clr, ov;
            int wb, dv;
            wrh = en && wr && (word || (ch == c));
            wb  = (word && c == 0) ? (wd >> 8) & 255 : wd & 255;
            case ((m_ctl[c] >> 1) & 3)
                0: dv = 1;
                1: dv = 8;
                2: dv = 32;
                default: dv = 64;
            endcase
            tick = (k % dv) == dv - 1;
            src  = (c == 0 && (m_ctl[0] & 1) != 0) ? ovf1 : tick;
            e    = src && !(wrh && a == 0);
            ha   = e && m_cnt[c] == m_ca[c];
            hb   = e && m_cnt[c] == m_cb[c];
            clr  = ha && (m_ctl[c] & 8) != 0;
            ov   = e && !clr && m_cnt[c] == 255;
            if (wrh && a == 0) m_cnt[c] = wb;
            else if (clr)      m_cnt[c] = 0;
            else if (e)        m_cnt[c] = (m_cnt[c] + 1) % 256;
            if (wrh && a == 1) m_ca[c]  = wb;
            if (wrh && a == 2) m_cb[c]  = wb;
            if (wrh && a == 3) m_ctl[c] = wb & 15;
            if (wrh && a == 4) m_st[c]  = m_st[c] & wb & 7;
            m_st[c] = m_st[c] | (ov ? 4 : 0) | (hb ? 2 : 0) | (ha ? 1 : 0);
            if (c == 1) ovf1 = ov;
        end
    endfunction

    task automatic cyc(bit en, bit wr, bit word, bit ch, int a, int wd);
        int exp_v;
        bus_en = en; bus_wr = wr; bus_word = word; bus_ch = ch;
        bus_addr = 3'(a); bus_wdata = 16'(wd);
        #1;
        exp_v = model_rd(en, wr, word, ch, a);
        n_chk++;
        if (bus_rdata !== 16'(exp_v)) begin
            n_fail++;
            $display("FAIL %s k=%0d addr=%0d: got %h exp %h", cur, k, a, bus_rdata, 16'(exp_v));
        end
        @(posedge clk);
        model_step(en, wr, word, ch, a, wd);
        k++;
        @(negedge clk);
    endtask

    task automatic rdw(int a);               cyc(1, 0, 1, 0, a, 0);  endtask
    task automatic rdb(bit ch, int a);       cyc(1, 0, 0, ch, a, 0); endtask
    task automatic wrw(int a, int d);        cyc(1, 1, 1, 0, a, d);  endtask
    task automatic wrb(bit ch, int a, int d); cyc(1, 1, 0, ch, a, d); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired in %s", cur);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_ca[c] = 0; m_cb[c] = 0; m_ctl[c] = 0; m_st[c] = 0;
        end
        k = 0;
        rst_n = 1'b0;
        bus_en = 0; bus_wr = 0; bus_word = 0; bus_ch = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        // R4 / R12: reset state seen through reads, and idle bus reads zero
        bus_en = 1; bus_word = 1; #1;
        n_chk++;
        if (bus_rdata !== 16'h0000) begin
            n_fail++; $display("FAIL R4 reset count: got %h exp 0000", bus_rdata);
        end
        bus_en = 0;
        @(negedge clk);
        rst_n = 1'b1;

        cur = "R4";  rdw(0); rdw(0); rdb(0, 0); rdb(1, 0); rdw(0);
        cur = "R12"; cyc(0, 0, 1, 0, 0, 0); rdw(3); rdw(5); rdw(7);
        cur = "R1";  repeat (262) rdw(0);
        rdw(4);
        cur = "R8";  wrb(1, 4, 8'h03); rdw(4); wrw(4, 16'h0000); rdw(4); wrw(4, 16'hFFFF); rdw(4);
        cur = "R5";  wrw(1, 16'h2040); wrb(1, 2, 8'h55); wrb(0, 2, 8'h11);
        rdw(1); rdw(2); rdb(0, 1); rdb(1, 2); rdb(0, 2);
        cur = "R2";  wrb(1, 3, 8'h02); wrb(0, 3, 8'h06);
        repeat (150) rdw(0);
        wrb(1, 3, 8'h04); repeat (80) rdw(0);
        cur = "R7";  wrw(4, 0); wrb(1, 3, 0); wrb(1, 1, 8'h30); wrb(1, 2, 8'h38);
        wrb(1, 0, 8'h20); wrb(1, 4, 0);
        for (int i = 0; i < 15; i++) begin rdb(1, 4); rdb(1, 0); end
        cur = "R9";  wrb(1, 3, 8'h08); wrb(1, 1, 8'h10); wrb(1, 0, 0); wrb(1, 4, 0);
        repeat (40) rdb(1, 0);
        rdw(4);
        cur = "R3";  wrb(1, 3, 0); wrw(1, 0); wrb(0, 3, 8'h01); wrw(0, 16'h10F8);
        repeat (30) rdw(0);
        wrb(1, 3, 8'h01); repeat (280) rdw(0);
        rdw(3);
        cur = "R6";  wrb(1, 3, 8'h06); wrb(1, 0, 0);
        repeat (20) rdb(0, 0);
        repeat (5) rdb(0, 4);
        cur = "R11"; wrb(1, 3, 0); wrb(1, 0, 8'hFF); wrb(0, 0, 8'h77);
        rdw(0); rdw(0); wrb(1, 0, 8'hFF); rdw(0); rdw(0);
        cur = "R10"; wrw(0, 16'hABFE); rdw(0); rdw(0); rdw(0);
        wrw(3, 16'h0000); wrw(1, 16'h1234); rdw(1); rdb(0, 1); rdb(1, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule